// File: doc/BRIEF.md
# Address-Translation Unit Control and Interrupt Register Block

This block is the register file of an I/O address-translation unit. Software uses it to configure idle behaviour, to issue a soft reset and see when that reset completes, and to switch on translation and the table walker. It also programs the translation-table base and handles faults. The translation datapath and the table walker sit outside the block. They receive the control bits and the table base as plain outputs, and they report faults back as single-cycle event pulses together with the device address involved.

Each of the five fault sources latches into its own status bit, whether or not that source is enabled. The block keeps the address of the first fault that arrives while no status bit is pending. A single level interrupt is raised while any latched source is also enabled. Software clears status bits by writing ones to them. The register port is a single-cycle write strobe with a combinational read: the read data follows the address in the same cycle.

Top module: `xlat_ctl_regs`

## Requirements
- R1: Word offset 0x00 is the revision register. It reads 0x00000011, with major version 1 in bits [7:4] and minor version 1 in bits [3:0]. Writes to it have no effect.
- R2: The configuration register at offset 0x04 stores the idle mode in bits [4:3] (0 = force idle, 1 = no idle, 2 = smart idle) and auto-idle in bit 0. Both read back and drive `idle_mode` and `auto_idle`. Bit 2 reads 0.
- R3: Writing a 1 to configuration bit 1 is a soft reset. At that clock edge, configuration, interrupt status, interrupt enable, control, table base and fault address all return to 0, and the other bits of that write are discarded. Bit 1 always reads 0.
- R4: Bit 0 of the status register at offset 0x08 is reset-done. It is 1 after the hardware reset. It is 0 from the soft-reset edge onward and becomes 1 again exactly 4 clock edges after that edge.
- R5: Fault input bit 0 is TLB miss, bit 1 translation fault, bit 2 emulator miss, bit 3 table-walk fault and bit 4 multi-hit fault. A pulse on a fault input sets the same bit of the interrupt status register at offset 0x0C, even when that bit's enable is 0.
- R6: Writing to the interrupt status register clears each status bit written as 1 and leaves the bits written as 0 unchanged. If a fault event for a bit arrives in the same cycle as the clear, the bit stays set.
- R7: The interrupt enable register at offset 0x10 holds one enable per source in bits [4:0]. `irq` is high exactly while some status bit and its enable bit are both 1.
- R8: The control register at offset 0x14 uses bit 1 to enable translation (`mmu_en`), bit 2 to enable the table walker (`walk_en`) and bit 3 for the emulator TLB (`emu_tlb`). All other bits read 0.
- R9: The fault address register at offset 0x18 is read-only. It captures `fault_va` on a fault event only when no status bit is pending, so later faults keep the first address until the status is cleared.
- R10: The table base register at offset 0x1C ignores writes to bits [13:0], which always read 0. Bits [31:14] are stored and drive `table_base`.
- R11: Offsets 0x20 to 0x3C read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| fault_evt | input | 5 | Fault event pulses, one per source |
| fault_va | input | 32 | Device address that goes with `fault_evt` |
| irq | output | 1 | Level interrupt |
| mmu_en | output | 1 | Translation enable |
| walk_en | output | 1 | Table walker enable |
| emu_tlb | output | 1 | Emulator TLB control |
| table_base | output | 32 | Translation-table base, 16 KB aligned |
| idle_mode | output | 2 | Idle mode field |
| auto_idle | output | 1 | Auto-idle bit |

## Verification
The assertions check these properties on every cycle:
- a soft reset drops reset-done and clears the control bits, the table base and the interrupt;
- a status bit only appears after a fault event;
- the fault address is held while a status bit is pending;
- revision reads, unmapped reads and the low bits of the base read are constant.

The exact four-edge delay of reset-done, the read-back of every field and the first-fault capture across a clear are shown only by the bench's scenarios. The same holds for an event that arrives in the same cycle as a clear. The random phase mixes register writes, fault events and reads, and compares every read and every output against a model.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;

  // word indices of the register map
  localparam int unsigned IDX_REV   = 0;
  localparam int unsigned IDX_CFG   = 1;
  localparam int unsigned IDX_STAT  = 2;
  localparam int unsigned IDX_IRQS  = 3;
  localparam int unsigned IDX_IRQE  = 4;
  localparam int unsigned IDX_CTL   = 5;
  localparam int unsigned IDX_FADDR = 6;
  localparam int unsigned IDX_TBASE = 7;

  // configuration bit positions
  localparam int unsigned CFG_AUTOIDLE = 0;
  localparam int unsigned CFG_SRST     = 1;
  localparam int unsigned CFG_IDLE_LSB = 3;

  // control field sits at bits [3:1]
  localparam int unsigned CTL_LSB = 1;
  localparam int unsigned CTL_W   = 3;

  typedef enum logic [1:0] {
    IDLE_FORCE = 2'd0,
    IDLE_NONE  = 2'd1,
    IDLE_SMART = 2'd2,
    IDLE_RSVD  = 2'd3
  } idle_mode_e;

  // sticky status update: clear ones written, events win
  function automatic logic w1c_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  // irq level from latched status and enables
  function automatic logic irq_level(input logic [31:0] stat, input logic [31:0] en);
    return |(stat & en);
  endfunction

endpackage

// File: rtl/xlat_cfg_unit.sv
module xlat_cfg_unit
  import xlat_regs_pkg::*;
#(
  parameter int unsigned DONE_DLY = 4,
  localparam int unsigned CNT_W = $clog2(DONE_DLY + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] wr_idle,
  input  logic       wr_srst,
  input  logic       wr_autoidle,
  output logic       sw_rst,
  output idle_mode_e idle_mode,
  output logic       auto_idle,
  output logic       reset_done
);

  logic [CNT_W-1:0] done_cnt;
  logic             cnt_last;

  assign sw_rst   = cfg_we & wr_srst;
  assign cnt_last = (done_cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_mode  <= IDLE_FORCE;
      auto_idle  <= 1'b0;
      done_cnt   <= '0;
      reset_done <= 1'b1;
    end else if (sw_rst) begin
      idle_mode  <= IDLE_FORCE;
      auto_idle  <= 1'b0;
      done_cnt   <= CNT_W'(DONE_DLY);
      reset_done <= 1'b0;
    end else begin
      if (cfg_we) begin
        idle_mode <= idle_mode_e'(wr_idle);
        auto_idle <= wr_autoidle;
      end
      if (done_cnt != '0) done_cnt <= done_cnt - CNT_W'(1);
      if (cnt_last) reset_done <= 1'b1;
    end
  end

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !reset_done); // R4
  AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_done) |-> $past(cnt_last) && !$past(sw_rst)); // R4
  AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (idle_mode == IDLE_FORCE) && !auto_idle); // R3

endmodule

// File: rtl/xlat_irq_unit.sv
module xlat_irq_unit
  import xlat_regs_pkg::*;
#(
  parameter int unsigned N_SRC  = 5,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              stat_we,
  input  logic              en_we,
  input  logic [N_SRC-1:0]  wdata,
  input  logic [N_SRC-1:0]  evt,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic [N_SRC-1:0]  status,
  output logic [N_SRC-1:0]  enable,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              irq
);

  logic pending;
  logic capture;

  assign pending = |status;
  assign capture = (|evt) & ~pending;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bit_q <= 1'b0;
      else if (sw_rst)  bit_q <= 1'b0;
      else              bit_q <= w1c_next(bit_q, stat_we & wdata[g], evt[g]);
    end
    assign status[g] = bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable     <= '0;
      fault_addr <= '0;
    end else if (sw_rst) begin
      enable     <= '0;
      fault_addr <= '0;
    end else begin
      if (en_we)   enable     <= wdata;
      if (capture) fault_addr <= evt_addr;
    end
  end

  assign irq = irq_level(32'(status), 32'(enable));

  AST_STATUS_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    |(status & ~$past(status)) |-> |$past(evt)); // R5
  AST_FIRST_FAULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending) && !$past(sw_rst)) |-> $stable(fault_addr)); // R9
  AST_IRQ_QUIET_AFTER_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_rst) |-> !irq); // R3

endmodule

// File: rtl/xlat_ctl_unit.sv
module xlat_ctl_unit
  import xlat_regs_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE_LSB = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_rst,
  input  logic                       ctl_we,
  input  logic                       base_we,
  input  logic [CTL_W-1:0]           wr_ctl,
  input  logic [DATA_W-1:BASE_LSB]   wr_base,
  output logic [CTL_W-1:0]           ctl_bits,
  output logic [DATA_W-1:BASE_LSB]   base_hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_bits <= '0;
      base_hi  <= '0;
    end else if (sw_rst) begin
      ctl_bits <= '0;
      base_hi  <= '0;
    end else begin
      if (ctl_we)  ctl_bits <= wr_ctl;
      if (base_we) base_hi  <= wr_base;
    end
  end

  AST_CTL_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (ctl_bits == '0) && (base_hi == '0)); // R3
  AST_BASE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(base_we) && !$past(sw_rst)) |-> $stable(base_hi)); // R10
  AST_CTL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctl_we) && !$past(sw_rst)) |-> $stable(ctl_bits)); // R8

endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
  import xlat_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_SRC    = 5,
  parameter int unsigned DONE_DLY = 4,
  parameter int unsigned BASE_LSB = 14,
  parameter logic [31:0] REV_ID   = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  fault_evt,
  input  logic [DATA_W-1:0] fault_va,
  output logic              irq,
  output logic              mmu_en,
  output logic              walk_en,
  output logic              emu_tlb,
  output logic [DATA_W-1:0] table_base,
  output logic [1:0]        idle_mode,
  output logic              auto_idle
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             we_cfg, we_irqs, we_irqe, we_ctl, we_tbase;
  logic             sw_rst;
  logic             reset_done;
  idle_mode_e       idle_q;
  logic [N_SRC-1:0] status, enable;
  logic [DATA_W-1:0] fault_addr;
  logic [CTL_W-1:0] ctl_bits;
  logic [DATA_W-1:BASE_LSB] base_hi;
  logic             unused_bits;

  assign widx        = reg_addr[ADDR_W-1:2];
  assign unused_bits = ^{reg_wdata, reg_addr[1:0]};

  assign we_cfg   = reg_we && (widx == IDX_W'(IDX_CFG));
  assign we_irqs  = reg_we && (widx == IDX_W'(IDX_IRQS));
  assign we_irqe  = reg_we && (widx == IDX_W'(IDX_IRQE));
  assign we_ctl   = reg_we && (widx == IDX_W'(IDX_CTL));
  assign we_tbase = reg_we && (widx == IDX_W'(IDX_TBASE));

  xlat_cfg_unit #(.DONE_DLY(DONE_DLY)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (we_cfg),
    .wr_idle     (reg_wdata[CFG_IDLE_LSB+1:CFG_IDLE_LSB]),
    .wr_srst     (reg_wdata[CFG_SRST]),
    .wr_autoidle (reg_wdata[CFG_AUTOIDLE]),
    .sw_rst      (sw_rst),
    .idle_mode   (idle_q),
    .auto_idle   (auto_idle),
    .reset_done  (reset_done)
  );

  xlat_irq_unit #(.N_SRC(N_SRC), .ADDR_W(DATA_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .stat_we    (we_irqs),
    .en_we      (we_irqe),
    .wdata      (reg_wdata[N_SRC-1:0]),
    .evt        (fault_evt),
    .evt_addr   (fault_va),
    .status     (status),
    .enable     (enable),
    .fault_addr (fault_addr),
    .irq        (irq)
  );

  xlat_ctl_unit #(.DATA_W(DATA_W), .BASE_LSB(BASE_LSB)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .ctl_we   (we_ctl),
    .base_we  (we_tbase),
    .wr_ctl   (reg_wdata[CTL_LSB+CTL_W-1:CTL_LSB]),
    .wr_base  (reg_wdata[DATA_W-1:BASE_LSB]),
    .ctl_bits (ctl_bits),
    .base_hi  (base_hi)
  );

  assign mmu_en     = ctl_bits[0];
  assign walk_en    = ctl_bits[1];
  assign emu_tlb    = ctl_bits[2];
  assign table_base = {base_hi, {BASE_LSB{1'b0}}};
  assign idle_mode  = idle_q;

  function automatic logic [DATA_W-1:0] read_mux(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] v;
    v = '0;
    case (int'(idx))
      IDX_REV:   v = DATA_W'(REV_ID);
      IDX_CFG: begin
        v[CFG_IDLE_LSB +: 2] = idle_q;
        v[CFG_AUTOIDLE]      = auto_idle;
      end
      IDX_STAT:  v[0] = reset_done;
      IDX_IRQS:  v[N_SRC-1:0] = status;
      IDX_IRQE:  v[N_SRC-1:0] = enable;
      IDX_CTL:   v[CTL_LSB +: CTL_W] = ctl_bits;
      IDX_FADDR: v = fault_addr;
      IDX_TBASE: v = table_base;
      default:   v = '0;
    endcase
    return v;
  endfunction

  assign reg_rdata = read_mux(widx);

  AST_REV_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (widx == IDX_W'(IDX_REV)) |-> (reg_rdata == DATA_W'(REV_ID))); // R1
  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (widx == IDX_W'(IDX_TBASE)) |-> (reg_rdata[BASE_LSB-1:0] == '0)); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(widx) > IDX_TBASE) |-> (reg_rdata == '0)); // R11
  AST_SRST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (widx == IDX_W'(IDX_CFG)) |-> !reg_rdata[CFG_SRST]); // R3

endmodule

// File: tb/xlat_ctl_regs_tb.sv
module xlat_ctl_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  fault_evt = '0;
  logic [31:0] fault_va = '0;
  logic        irq, mmu_en, walk_en, emu_tlb, auto_idle;
  logic [31:0] table_base;
  logic [1:0]  idle_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  // bench model
  logic [1:0]  m_idle;
  logic        m_ai;
  logic        m_done;
  logic [4:0]  m_stat, m_en;
  logic [2:0]  m_ctl;
  logic [31:0] m_fa, m_tb;

  always #5 clk = ~clk;

  xlat_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_evt(fault_evt),
    .fault_va(fault_va), .irq(irq), .mmu_en(mmu_en), .walk_en(walk_en),
    .emu_tlb(emu_tlb), .table_base(table_base), .idle_mode(idle_mode),
    .auto_idle(auto_idle)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_idle = 0; m_ai = 0; m_stat = 0; m_en = 0; m_ctl = 0; m_fa = 0; m_tb = 0;
  endtask

  function automatic logic [31:0] exp_read(input int idx);
    case (idx)
      0: return 32'h0000_0011;
      1: return {27'd0, m_idle, 2'b00, m_ai};
      2: return {31'd0, m_done};
      3: return {27'd0, m_stat};
      4: return {27'd0, m_en};
      5: return {28'd0, m_ctl, 1'b0};
      6: return m_fa;
      7: return m_tb;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input int idx);
    case (idx)
      0: return "R1"; 1: return "R2"; 2: return "R4"; 3: return "R5";
      4: return "R7"; 5: return "R8"; 6: return "R9"; 7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_write(input int idx, input logic [31:0] d);
    case (idx)
      1: begin m_idle = d[4:3]; m_ai = d[0]; end
      3: m_stat = m_stat & ~d[4:0];
      4: m_en = d[4:0];
      5: m_ctl = d[3:1];
      7: m_tb = d & 32'hFFFF_C000;
      default: ;
    endcase
  endtask

  task automatic model_event(input logic [4:0] b, input logic [31:0] va);
    if (b != 0 && m_stat == 0) m_fa = va;
    m_stat = m_stat | b;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(idx * 4); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    model_write(idx, d);
  endtask

  task automatic pulse(input logic [4:0] b, input logic [31:0] va);
    @(negedge clk);
    fault_evt = b; fault_va = va;
    @(negedge clk);
    fault_evt = '0;
    model_event(b, va);
  endtask

  task automatic rd_check(input int idx);
    reg_addr = 6'(idx * 4);
    #1;
    check(req_of(idx), reg_rdata, exp_read(idx));
  endtask

  task automatic outs_check();
    #1;
    check("R7 irq", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
    check("R8 outs", {29'd0, emu_tlb, walk_en, mmu_en}, {29'd0, m_ctl});
    check("R10 base", table_base, m_tb);
    check("R2 outs", {29'd0, idle_mode, auto_idle}, {29'd0, m_idle, m_ai});
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    model_reset();
    m_done = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    for (int i = 0; i < 16; i++) rd_check(i);
    outs_check();

    // R1 revision ignores writes
    wr(0, 32'hFFFF_FFFF);
    rd_check(0);
    check("R1 major", {28'd0, reg_rdata[7:4]}, 32'd1);

    // R2 idle modes
    wr(1, 32'h0000_0011); rd_check(1); outs_check();
    wr(1, 32'h0000_0008); rd_check(1); outs_check();
    wr(1, 32'h0000_0005); rd_check(1); outs_check();

    // R10 base alignment
    wr(7, 32'hFFFF_FFFF); rd_check(7); outs_check();
    // R8 control
    wr(5, 32'hFFFF_FFFF); rd_check(5); outs_check();
    // R11 unmapped
    wr(12, 32'hDEAD_BEEF); rd_check(12);

    // R5 latch without enable, R7 irq follows enable
    pulse(5'b00100, 32'h1234_5000);
    rd_check(3); outs_check();
    wr(4, 32'h0000_0004); outs_check();
    // R9 second fault keeps first address
    pulse(5'b10000, 32'h9999_0000);
    rd_check(6); rd_check(3);
    // R6 clear one bit
    wr(3, 32'h0000_0004); rd_check(3); outs_check();
    wr(3, 32'h0000_001F); rd_check(3); outs_check();
    // R9 capture again after clear
    pulse(5'b00001, 32'hABCD_0000);
    rd_check(6);
    // R6 event and clear in the same cycle: event wins
    @(negedge clk);
    reg_we = 1; reg_addr = 6'd12; reg_wdata = 32'h1; fault_evt = 5'b00011; fault_va = 32'h5555_0000;
    @(negedge clk);
    reg_we = 0; fault_evt = 0;
    m_stat = (m_stat & ~5'b00001) | 5'b00011;
    rd_check(3); check("R6 kept", {31'd0, reg_rdata[0]}, 32'd1);
    rd_check(6);

    // R3 / R4 soft reset with everything set
    wr(4, 32'h1F); wr(5, 32'hE);
    @(negedge clk);
    reg_we = 1; reg_addr = 6'd4; reg_wdata = 32'h0000_0013;
    @(negedge clk);
    reg_we = 0;
    model_reset(); m_done = 0;
    for (int i = 0; i < 8; i++) rd_check(i);
    outs_check();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      reg_addr = 6'd8; #1;
      check("R4 still low", reg_rdata, 32'd0);
    end
    @(negedge clk);
    m_done = 1;
    rd_check(2);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      int idx;
      logic [31:0] d;
      op = int'($urandom % 4);
      idx = int'($urandom % 16);
      d = $urandom;
      case (op)
        0: begin
          if (idx == 1) d[1] = 1'b0;
          wr(idx, d);
        end
        1: pulse(5'($urandom), $urandom);
        2: rd_check(idx);
        default: outs_check();
      endcase
    end
    for (int i = 0; i < 16; i++) rd_check(i);
    outs_check();
    finish_run();
  end

endmodule